// File: doc/BRIEF.md
# Interrupt Pin Latch and Delivery Scanner

This block sits between a bank of interrupt request lines and the message fabric that carries interrupts to processors. Each line feeds one pin. Each pin has a 64-bit routing entry, and all the entries are supplied together as one flat vector. The block records requests in per-pin pending bits. For each pending pin whose entry is not masked, it builds a delivery message from that pin's own entry and offers it on a valid/ready handshake. When several pins are pending, the one with the lowest number goes first. When a new selection is due, the search starts again at pin 0.

A pin can be in one of two trigger modes. In edge mode its pending bit sets on a rising edge of the line and clears when the message is issued. In level mode its pending bit follows the line, so a line that stays high keeps producing messages. When an entry selects external-interrupt delivery, the block first runs an acknowledge handshake with an external interrupt controller, and the vector returned there replaces the entry's vector. A configuration input can route request line 0 to pin 2. Lines are active high, and the polarity field is only carried in the message.

Top module: `irq_pin_scanner`

## Requirements
- R1: After reset, `msgValid` and `extAckReq` are low and no pin is pending.
- R2: A message carries fields decoded from the selected pin's entry: destination from bits 63:56, destination mode from bit 11, delivery mode from bits 10:8, vector from bits 7:0, polarity from bit 13 and trigger mode from bit 15.
- R3: A pin whose entry bit 16 is 1 (masked) is never delivered. A rising edge that arrives while the pin is masked is still recorded, and it is delivered once the mask bit is cleared.
- R4: In edge mode (bit 15 = 0), each rising edge of the line yields exactly one message. A line held high produces no further messages.
- R5: In level mode (bit 15 = 1), the pending bit follows the line. While the line stays high, the pin is delivered again after each accepted message. A line that falls while the pin is masked leaves nothing to deliver.
- R6: When several unmasked pins are pending, messages are issued in ascending pin order.
- R7: Only one message is outstanding at a time. While `msgValid` is high and `msgReady` is low, `msgValid` stays high and every message field holds its value, even if the table changes.
- R8: A rising edge on an edge-mode pin that arrives while that pin's message is outstanding produces a further message, built from the entry as it stands at that later time.
- R9: For delivery mode code 7, `extAckReq` rises and no message is offered until `extAckDone` is seen. The message then carries `extVector`, sampled in that cycle, as its vector. `extAckReq` and `msgValid` are never high together.
- R10: With `remapLine0En` high, line 0 drives pin 2 and pin 0 receives nothing. With it low, line 0 drives pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | 24 | Interrupt request lines, active high |
| redirTable | input | 1536 | Routing entries, pin i in bits [64*i+63 : 64*i] |
| remapLine0En | input | 1 | Route line 0 to pin 2 |
| msgValid | output | 1 | Delivery message offered |
| msgReady | input | 1 | Delivery message accepted when high with msgValid |
| msgDest | output | 8 | Destination |
| msgDestMode | output | 1 | Destination mode |
| msgDelivMode | output | 3 | Delivery mode code |
| msgVector | output | 8 | Vector |
| msgPolarity | output | 1 | Polarity |
| msgTrigger | output | 1 | Trigger mode, 1 = level |
| extAckReq | output | 1 | Acknowledge request to external controller |
| extAckDone | input | 1 | External controller returns a vector |
| extVector | input | 8 | Vector from external controller |

## Verification
Edge-mode stimulus covers three cases: single pulses on pins with different field patterns, a line held high, and a second pulse while the first message is stalled. Together these separate one-message-per-edge from re-triggering, and show whether the clear on issue loses a fresh edge. Level-mode stimulus holds a line high across two accepts, then drops it while a message is stalled. This separates following the line from latching it. Simultaneous pulses on three pins expose the selection order. An external-delivery pin with a deliberately different table vector shows which vector source is used. Toggling the remap input with line 0 pulsed shows which pin line 0 reaches.

// File: rtl/irqscan_pkg.sv
package irqscan_pkg;

  localparam int ENTRY_W   = 64;
  localparam int BIT_MASK  = 16;
  localparam int BIT_TRIG  = 15;
  localparam int BIT_POL   = 13;
  localparam int BIT_DMODE = 11;
  localparam int DLV_LO    = 8;
  localparam int DEST_LO   = 56;
  localparam logic [2:0] DLV_EXTERNAL = 3'd7;

  typedef struct packed {
    logic       capture;     // latch the selected pin's message
    logic       takeExtVec;  // overwrite vector with external one
  } scanStrobe_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       destMode;
    logic [2:0] delivMode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } msgFields_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_SEND = 2'd2
  } scanState_t;

endpackage

// File: rtl/irqscan_datapath.sv
module irqscan_datapath
  import irqscan_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int REMAP_DST = 2,
  localparam int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS-1:0]           irqLines,
  input  logic [NUM_PINS*ENTRY_W-1:0]   redirTable,
  input  logic                          remapLine0En,
  input  logic [7:0]                    extVector,
  input  scanStrobe_t                   strobe,
  output logic                          anyCand,
  output logic                          candExternal,
  output msgFields_t                    msg
);

  logic [ENTRY_W-1:0]  entry [NUM_PINS];
  logic [NUM_PINS-1:0] maskBit, levelBit, effLine, lineQ, rise, pend, cand, clearHit;
  logic [PIN_W-1:0]    selIdx;
  logic [ENTRY_W-1:0]  selEntry;

  // per-pin entry slicing and line routing
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign entry[i]    = redirTable[i*ENTRY_W +: ENTRY_W];
    assign maskBit[i]  = entry[i][BIT_MASK];
    assign levelBit[i] = entry[i][BIT_TRIG];
    if (i == 0) begin : g_src
      assign effLine[i] = remapLine0En ? 1'b0 : irqLines[0];
    end else if (i == REMAP_DST) begin : g_dst
      assign effLine[i] = remapLine0En ? irqLines[0] : irqLines[i];
    end else begin : g_plain
      assign effLine[i] = irqLines[i];
    end
    assign rise[i]     = effLine[i] & ~lineQ[i];
    assign clearHit[i] = strobe.capture && (selIdx == PIN_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)           pend[i] <= 1'b0;
      else if (levelBit[i]) pend[i] <= effLine[i];
      else                  pend[i] <= rise[i] | (pend[i] & ~clearHit[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lineQ <= '0;
    else        lineQ <= effLine;
  end

  assign cand    = pend & ~maskBit;
  assign anyCand = |cand;

  // lowest-numbered candidate wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) selIdx = PIN_W'(i);
    end
  end

  assign selEntry     = entry[selIdx];
  assign candExternal = selEntry[DLV_LO +: 3] == DLV_EXTERNAL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg <= '0;
    end else if (strobe.capture) begin
      msg.dest      <= selEntry[DEST_LO +: 8];
      msg.destMode  <= selEntry[BIT_DMODE];
      msg.delivMode <= selEntry[DLV_LO +: 3];
      msg.vector    <= selEntry[7:0];
      msg.polarity  <= selEntry[BIT_POL];
      msg.trigger   <= selEntry[BIT_TRIG];
    end else if (strobe.takeExtVec) begin
      msg.vector    <= extVector;
    end
  end

  // R4: issuing an edge-mode pin without a fresh edge leaves it idle
  a_r4_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture && !selEntry[BIT_TRIG] && !rise[selIdx]
      |=> !pend[$past(selIdx)] || levelBit[$past(selIdx)]);

endmodule

// File: rtl/irqscan_ctrl.sv
module irqscan_ctrl
  import irqscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        anyCand,
  input  logic        candExternal,
  input  logic        msgReady,
  input  logic        extAckDone,
  output scanStrobe_t strobe,
  output logic        msgValid,
  output logic        extAckReq
);

  scanState_t state, nextState;

  always_comb begin
    nextState         = state;
    strobe            = '0;
    unique case (state)
      ST_IDLE: if (anyCand) begin
        strobe.capture = 1'b1;
        nextState      = candExternal ? ST_ACK : ST_SEND;
      end
      ST_ACK: if (extAckDone) begin
        strobe.takeExtVec = 1'b1;
        nextState         = ST_SEND;
      end
      ST_SEND: if (msgReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign msgValid  = state == ST_SEND;
  assign extAckReq = state == ST_ACK;

  // R1: after reset the handshake outputs start quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> !msgValid && !extAckReq);

endmodule

// File: rtl/irq_pin_scanner.sv
module irq_pin_scanner
  import irqscan_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int REMAP_DST = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irqLines,
  input  logic [NUM_PINS*ENTRY_W-1:0] redirTable,
  input  logic                        remapLine0En,
  output logic                        msgValid,
  input  logic                        msgReady,
  output logic [7:0]                  msgDest,
  output logic                        msgDestMode,
  output logic [2:0]                  msgDelivMode,
  output logic [7:0]                  msgVector,
  output logic                        msgPolarity,
  output logic                        msgTrigger,
  output logic                        extAckReq,
  input  logic                        extAckDone,
  input  logic [7:0]                  extVector
);

  scanStrobe_t strobe;
  msgFields_t  msg;
  logic        anyCand, candExternal;

  irqscan_datapath #(.NUM_PINS(NUM_PINS), .REMAP_DST(REMAP_DST)) u_dp (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .redirTable(redirTable),
    .remapLine0En(remapLine0En), .extVector(extVector), .strobe(strobe),
    .anyCand(anyCand), .candExternal(candExternal), .msg(msg)
  );

  irqscan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyCand(anyCand), .candExternal(candExternal),
    .msgReady(msgReady), .extAckDone(extAckDone), .strobe(strobe),
    .msgValid(msgValid), .extAckReq(extAckReq)
  );

  assign msgDest      = msg.dest;
  assign msgDestMode  = msg.destMode;
  assign msgDelivMode = msg.delivMode;
  assign msgVector    = msg.vector;
  assign msgPolarity  = msg.polarity;
  assign msgTrigger   = msg.trigger;

  // R7: a stalled message keeps its valid and its fields
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msgValid && !msgReady |=> msgValid && $stable(msg));

  // R9: acknowledge and offer never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(msgValid && extAckReq));

  // R9: the acknowledged vector is what gets offered
  a_r9_ext_vector: assert property (@(posedge clk) disable iff (!rst_n)
    extAckReq && extAckDone |=> msgValid && msgVector == $past(extVector));

endmodule

// File: tb/irq_pin_scanner_bench.sv
module irq_pin_scanner_bench;

  localparam int NP = 24;
  localparam logic [63:0] MASKED = 64'h1_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, remapLine0En, msgValid, msgReady, extAckReq, extAckDone;
  logic [NP-1:0]    lines;
  logic [63:0]      tbl [NP];
  logic [NP*64-1:0] flat;
  logic [7:0]       msgDest, msgVector, extVector;
  logic             msgDestMode, msgPolarity, msgTrigger;
  logic [2:0]       msgDelivMode;
  int               nChecks = 0, nFails = 0;

  always_comb for (int i = 0; i < NP; i++) flat[i*64 +: 64] = tbl[i];

  irq_pin_scanner u_irq_pin_scanner (
    .clk(clk), .rst_n(rst_n), .irqLines(lines), .redirTable(flat),
    .remapLine0En(remapLine0En), .msgValid(msgValid), .msgReady(msgReady),
    .msgDest(msgDest), .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgVector(msgVector), .msgPolarity(msgPolarity), .msgTrigger(msgTrigger),
    .extAckReq(extAckReq), .extAckDone(extAckDone), .extVector(extVector)
  );

  function automatic logic [63:0] mkEntry(input logic [7:0] dest, input logic dm,
      input logic [2:0] dlv, input logic [7:0] vec, input logic pol,
      input logic trig, input logic msk);
    logic [63:0] e = '0;
    e[63:56] = dest; e[11] = dm; e[10:8] = dlv; e[7:0] = vec;
    e[13] = pol; e[15] = trig; e[16] = msk;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitMsg(output bit found);
    found = 0;
    for (int k = 0; k < 30 && !found; k++) begin
      @(negedge clk);
      if (msgValid) found = 1;
    end
  endtask

  task automatic accept();
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic pulse(input int p);
    @(negedge clk) lines[p] = 1'b1;
    repeat (2) @(negedge clk);
    lines[p] = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msgValid) seen = 1;
    end
    check(req, 32'(seen), 0);
  endtask

  task automatic t_reset();
    check("R1 msgValid", 32'(msgValid), 0);
    check("R1 extAckReq", 32'(extAckReq), 0);
    quiet("R1 no pending after reset", 5);
  endtask

  task automatic t_decode();
    bit f;
    tbl[5] = mkEntry(8'hA5, 1, 3'd1, 8'h42, 1, 0, 0);
    pulse(5);
    waitMsg(f);
    check("R2 found", 32'(f), 1);
    check("R2 dest", 32'(msgDest), 32'hA5);
    check("R2 destMode", 32'(msgDestMode), 1);
    check("R2 deliv", 32'(msgDelivMode), 1);
    check("R2 vector", 32'(msgVector), 32'h42);
    check("R2 polarity", 32'(msgPolarity), 1);
    check("R2 trigger", 32'(msgTrigger), 0);
    accept();
    quiet("R4 one message per edge", 8);
    tbl[9] = mkEntry(8'h3C, 0, 3'd4, 8'h77, 0, 0, 0);
    @(negedge clk) lines[9] = 1'b1;
    waitMsg(f);
    check("R2 second pattern vector", 32'(msgVector), 32'h77);
    check("R2 second pattern dest/deliv", {msgDest, 5'd0, msgDelivMode}, {8'h3C, 8'h04});
    check("R2 second pattern modes", {msgDestMode, msgPolarity}, 0);
    accept();
    quiet("R4 held line no repeat", 10);
    lines[9] = 1'b0;
    tbl[5] = MASKED; tbl[9] = MASKED;
  endtask

  task automatic t_mask();
    bit f;
    tbl[7] = mkEntry(8'h01, 0, 3'd0, 8'h70, 0, 0, 1);
    pulse(7);
    quiet("R3 masked not delivered", 10);
    @(negedge clk) tbl[7][16] = 1'b0;
    waitMsg(f);
    check("R3 delivered after unmask", 32'(f), 1);
    check("R3 vector", 32'(msgVector), 32'h70);
    accept();
    quiet("R3 single delivery", 5);
    tbl[7] = MASKED;
  endtask

  task automatic t_level();
    bit f;
    tbl[3] = mkEntry(8'h02, 0, 3'd0, 8'h33, 0, 1, 0);
    @(negedge clk) lines[3] = 1'b1;
    waitMsg(f);
    check("R5 first level message", 32'(f), 1);
    check("R5 trigger field", 32'(msgTrigger), 1);
    accept();
    waitMsg(f);
    check("R5 redelivered while high", 32'(f), 1);
    lines[3] = 1'b0;
    repeat (3) @(negedge clk);
    accept();
    quiet("R5 stops after line falls", 10);
    tbl[3] = MASKED;
    tbl[12] = mkEntry(8'h02, 0, 3'd0, 8'hC0, 0, 1, 1);
    @(negedge clk) lines[12] = 1'b1;
    repeat (3) @(negedge clk);
    lines[12] = 1'b0;
    repeat (3) @(negedge clk);
    tbl[12][16] = 1'b0;
    quiet("R5 dropped while masked gives nothing", 10);
    tbl[12] = MASKED;
  endtask

  task automatic t_order();
    bit f;
    logic [7:0] got [3];
    tbl[4]  = mkEntry(0, 0, 3'd0, 8'h44, 0, 0, 0);
    tbl[10] = mkEntry(0, 0, 3'd0, 8'hA0, 0, 0, 0);
    tbl[20] = mkEntry(0, 0, 3'd0, 8'hB4, 0, 0, 0);
    @(negedge clk) begin lines[4] = 1; lines[10] = 1; lines[20] = 1; end
    repeat (2) @(negedge clk);
    lines[4] = 0; lines[10] = 0; lines[20] = 0;
    for (int k = 0; k < 3; k++) begin
      waitMsg(f);
      got[k] = msgVector;
      accept();
    end
    check("R6 first lowest", 32'(got[0]), 32'h44);
    check("R6 second", 32'(got[1]), 32'hA0);
    check("R6 third", 32'(got[2]), 32'hB4);
    tbl[4] = MASKED; tbl[10] = MASKED; tbl[20] = MASKED;
  endtask

  task automatic t_hold();
    bit f;
    tbl[14] = mkEntry(8'h0E, 1, 3'd0, 8'h5E, 0, 0, 0);
    pulse(14);
    waitMsg(f);
    tbl[14][7:0] = 8'h61;
    pulse(14);
    repeat (2) @(negedge clk);
    check("R7 valid held", 32'(msgValid), 1);
    check("R7 vector stable", 32'(msgVector), 32'h5E);
    check("R7 dest stable", 32'(msgDest), 32'h0E);
    accept();
    waitMsg(f);
    check("R8 edge during stall kept", 32'(f), 1);
    check("R8 uses later entry", 32'(msgVector), 32'h61);
    accept();
    quiet("R8 no extra message", 8);
    tbl[14] = MASKED;
  endtask

  task automatic t_external();
    bit f = 0;
    tbl[6] = mkEntry(8'h01, 0, 3'd7, 8'h11, 0, 0, 0);
    pulse(6);
    for (int k = 0; k < 30 && !f; k++) begin
      if (extAckReq) f = 1; else @(negedge clk);
    end
    check("R9 ack requested", 32'(f), 1);
    quiet("R9 no offer before ack", 4);
    check("R9 ack still held", 32'(extAckReq), 1);
    extVector = 8'h9C; extAckDone = 1'b1;
    @(negedge clk) begin extAckDone = 1'b0; extVector = 8'h00; end
    check("R9 offer after ack", 32'(msgValid), 1);
    check("R9 external vector", 32'(msgVector), 32'h9C);
    check("R9 deliv code", 32'(msgDelivMode), 7);
    check("R9 ack dropped", 32'(extAckReq), 0);
    accept();
    tbl[6] = MASKED;
  endtask

  task automatic t_remap();
    bit f;
    tbl[0] = mkEntry(0, 0, 3'd0, 8'h20, 0, 0, 0);
    tbl[2] = mkEntry(0, 0, 3'd0, 8'h22, 0, 0, 0);
    @(negedge clk) remapLine0En = 1'b1;
    pulse(0);
    waitMsg(f);
    check("R10 line0 reaches pin2", 32'(msgVector), 32'h22);
    accept();
    quiet("R10 pin0 untouched", 8);
    remapLine0En = 1'b0;
    pulse(0);
    waitMsg(f);
    check("R10 remap off reaches pin0", 32'(msgVector), 32'h20);
    accept();
    quiet("R10 single message", 5);
    tbl[0] = MASKED; tbl[2] = MASKED;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rst_n = 0; remapLine0En = 0; msgReady = 0; extAckDone = 0; extVector = 0;
    lines = '0;
    for (int i = 0; i < NP; i++) tbl[i] = MASKED;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_mask();
    t_level();
    t_order();
    t_hold();
    t_external();
    t_remap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule